// File: doc/BRIEF.md
# Serial Configuration Register Slave for a Sensor Front End

This block is the configuration port of an analog sensor front end. A host reaches it over a three-wire serial bus: an active-low select, a serial clock and one data line that the pad ring splits into an input, an output and an output enable. Each frame carries two bytes. The first is an instruction: a direction flag, a reserved field and a register address. The second is the data byte. All bus pins are sampled by the system clock through synchronizers, so the whole block runs in one clock domain.

Three byte-wide registers sit behind the port. The device setup register drives the amplifier enables, the filter path select, the common-mode select and the two gain codes. The offset register holds an 8-bit DAC code. The mode register is write-only and gates reads. After reset the port accepts writes only. A two-value key written to the mode register opens it for reads of the two readable registers. The select may also be held low permanently, in which case frames are delimited purely by counting clocks.

Top module: `cfgspi_slave`

## Requirements
- R1: The instruction byte is shifted in MSB first on rising serial clock edges. Bit 7 selects the direction (0 write, 1 read), bits 3:0 give the address, and bits 6:4 must be zero; an instruction with any of bits 6:4 set is ignored.
- R2: A write to address 0x0 sets the setup outputs from the data byte: bit 6 stage-1 amplifier enable, bit 5 stage-2 amplifier enable, bit 4 external filter path, bit 3 high common-mode level, bits 2:1 stage-2 gain code, bit 0 low stage-1 gain. Bit 7 is not stored and reads back as 0. No other frame changes these outputs.
- R3: A write to address 0x1 loads the 8-bit DAC code. No other frame changes it.
- R4: Reset (rst_n low at a clock edge) gives setup 0x00, DAC code 0x80 and a locked read port, whatever the state before.
- R5: Reads open only after 0xFE and then 0xED are written to address 0xF in consecutive writes to that address. Any other value written there locks the port again; 0xED alone does not open it.
- R6: In an opened read of address 0x0 or 0x1, the slave drives the register value MSB first during the data byte. It updates the output on each falling clock edge, starting with the falling edge after the eighth rising edge, and enables the output only then.
- R7: A read that is locked, or that targets 0xF or an undefined address, leaves the output enable low. Writes to undefined addresses change nothing.
- R8: Raising the select aborts a frame in progress without effect. The next falling select starts a fresh instruction byte.
- R9: With the select held low, consecutive frames of exactly 16 clocks each are decoded back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the serial bus |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_csn | input | 1 | Active-low frame select |
| spi_sdi | input | 1 | Data line, input side of the pad |
| spi_sdo | output | 1 | Data line, output side of the pad |
| spi_sdo_en | output | 1 | Output enable for the data pad |
| pga1_on | output | 1 | Stage-1 amplifier enable |
| pga2_on | output | 1 | Stage-2 amplifier enable |
| filt_ext_sel | output | 1 | Route stage 1 to stage 2 through the external filter |
| cm_high_sel | output | 1 | Select the higher common-mode level |
| stage2_gain | output | 2 | Stage-2 gain code |
| stage1_low_gain | output | 1 | Select the low stage-1 gain |
| dac_code | output | 8 | Offset DAC code |

## Verification
The assertions assume that the serial clock and select change slowly compared with the system clock. Each level must last at least three system clocks, so that every edge passes the synchronizers and is seen exactly once. They also assume that the data input is steady across each rising serial edge. The stimulus holds every serial clock phase for four system clocks, changes data only while the serial clock is low, and keeps the select high for several clocks between frames. Held-low select runs use frames of exactly sixteen clocks.

// File: rtl/cfgspi_pkg.sv
// Shared constants and types for the serial configuration slave.
// Assumes byte-wide registers and a 4-bit address field.
package cfgspi_pkg;
    localparam int BYTE_W     = 8;
    localparam int ADDR_W     = 4;
    localparam int FRAME_BITS = 2 * BYTE_W;
    localparam int CNT_W      = $clog2(FRAME_BITS);

    localparam logic [ADDR_W-1:0] ADDR_SETUP  = 4'h0;
    localparam logic [ADDR_W-1:0] ADDR_OFFSET = 4'h1;
    localparam logic [ADDR_W-1:0] ADDR_MODE   = 4'hF;

    typedef enum logic [1:0] {
        LOCK_SHUT = 2'd0,
        LOCK_HALF = 2'd1,
        LOCK_OPEN = 2'd2
    } lock_state_t;

    typedef struct packed {
        logic       pga1_on;
        logic       pga2_on;
        logic       filt_ext;
        logic       cm_high;
        logic [1:0] stage2_gain;
        logic       stage1_low;
    } setup_t;
endpackage

// File: rtl/cfgspi_sync.sv
// Multi-bit level synchronizer for slow asynchronous pins.
// Assumes each bit is an independent level held longer than STAGES clocks.
module cfgspi_sync #(
    parameter int               WIDTH     = 3,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        if (STAGES <= 1) begin : g_single
            logic [WIDTH-1:0] stage_q;
            // Single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= RESET_VAL;
                else        stage_q <= d;
            end
            assign q = stage_q;
        end else begin : g_chain
            logic [STAGES*WIDTH-1:0] chain_q;
            // Shift the pin levels through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
                else        chain_q <= {chain_q[(STAGES-1)*WIDTH-1:0], d};
            end
            assign q = chain_q[STAGES*WIDTH-1 -: WIDTH];
        end
    endgenerate
endmodule

// File: rtl/cfgspi_frame.sv
// Frame engine: finds serial clock edges, counts 16-bit frames, captures the
// instruction and data bytes, issues write strobes and shifts read data out.
// Assumes synchronized inputs, MSB-first bits, rising-edge sampling and
// falling-edge output. A high select clears the frame at once.
module cfgspi_frame
    import cfgspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              csn_s,
    input  logic              sdi_s,
    input  logic              rd_ok,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sdo,
    output logic              sdo_en
);
    logic              sclk_d;
    logic              sclk_rise, sclk_fall;
    logic [BYTE_W-2:0] in_sh;
    logic [BYTE_W-1:0] next_byte;
    logic [BYTE_W-1:0] instr_q;
    logic [BYTE_W-1:0] tx_sh;
    logic [CNT_W-1:0]  bit_cnt;
    logic              rd_act;
    logic              instr_end, frame_end, next_legal, instr_legal;

    // Remember the last synchronized clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b1;
        else        sclk_d <= sclk_s;
    end

    // Decode edges, boundaries and instruction legality.
    always_comb begin
        sclk_rise   = sclk_s & ~sclk_d;
        sclk_fall   = ~sclk_s & sclk_d;
        next_byte   = {in_sh, sdi_s};
        instr_end   = (bit_cnt == CNT_W'(BYTE_W - 1));
        frame_end   = (bit_cnt == CNT_W'(FRAME_BITS - 1));
        next_legal  = (next_byte[BYTE_W-2:ADDR_W] == '0);
        instr_legal = (instr_q[BYTE_W-2:ADDR_W] == '0);
        rd_addr     = next_byte[ADDR_W-1:0];
    end

    // Frame sequencing: shift in, capture, write strobe, read shift-out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_sh   <= '0;
            instr_q <= '0;
            tx_sh   <= '0;
            bit_cnt <= '0;
            rd_act  <= 1'b0;
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            sdo     <= 1'b0;
            sdo_en  <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            if (csn_s) begin
                bit_cnt <= '0;
                rd_act  <= 1'b0;
                sdo_en  <= 1'b0;
            end else if (sclk_rise) begin
                in_sh   <= next_byte[BYTE_W-2:0];
                bit_cnt <= frame_end ? '0 : bit_cnt + 1'b1;
                if (instr_end) begin
                    instr_q <= next_byte;
                    if (next_byte[BYTE_W-1] && next_legal && rd_ok) begin
                        rd_act <= 1'b1;
                        tx_sh  <= rd_data;
                    end
                end
                if (frame_end) begin
                    rd_act <= 1'b0;
                    sdo_en <= 1'b0;
                    if (!instr_q[BYTE_W-1] && instr_legal) begin
                        wr_stb  <= 1'b1;
                        wr_addr <= instr_q[ADDR_W-1:0];
                        wr_data <= next_byte;
                    end
                end
            end else if (sclk_fall && rd_act) begin
                sdo    <= tx_sh[BYTE_W-1];
                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                sdo_en <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfgspi_regs.sv
// Register file: setup register, offset DAC code and the read-unlock state.
// Assumes at most one write strobe per frame. Decides read access from the
// address captured at the end of the instruction byte.
module cfgspi_regs
    import cfgspi_pkg::*;
#(
    parameter logic [BYTE_W-1:0] KEY_FIRST  = 8'hFE,
    parameter logic [BYTE_W-1:0] KEY_SECOND = 8'hED,
    parameter logic [BYTE_W-1:0] DAC_RESET  = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ok,
    output logic [BYTE_W-1:0] rd_data,
    output setup_t            setup_q,
    output logic [BYTE_W-1:0] dac_q,
    output lock_state_t       lock_q
);
    // Setup register update.
    always_ff @(posedge clk) begin
        if (!rst_n)                               setup_q <= '0;
        else if (wr_stb && wr_addr == ADDR_SETUP) setup_q <= setup_t'(wr_data[BYTE_W-2:0]);
    end

    // Offset DAC code update.
    always_ff @(posedge clk) begin
        if (!rst_n)                                dac_q <= DAC_RESET;
        else if (wr_stb && wr_addr == ADDR_OFFSET) dac_q <= wr_data;
    end

    // Unlock sequence tracking on writes to the mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= LOCK_SHUT;
        end else if (wr_stb && wr_addr == ADDR_MODE) begin
            if (wr_data == KEY_FIRST)                               lock_q <= LOCK_HALF;
            else if (wr_data == KEY_SECOND && lock_q == LOCK_HALF)  lock_q <= LOCK_OPEN;
            else                                                    lock_q <= LOCK_SHUT;
        end
    end

    // Read permission and read data selection.
    always_comb begin
        rd_ok   = (lock_q == LOCK_OPEN) &&
                  (rd_addr == ADDR_SETUP || rd_addr == ADDR_OFFSET);
        rd_data = '0;
        if (rd_addr == ADDR_SETUP)       rd_data = {1'b0, setup_q};
        else if (rd_addr == ADDR_OFFSET) rd_data = dac_q;
    end
endmodule

// File: rtl/cfgspi_slave.sv
// Top of the serial configuration slave: synchronizes the bus pins, runs
// the frame engine and exposes the decoded configuration fields.
// Assumes serial clock and select levels last at least three clk cycles.
module cfgspi_slave
    import cfgspi_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [BYTE_W-1:0] KEY_FIRST   = 8'hFE,
    parameter logic [BYTE_W-1:0] KEY_SECOND  = 8'hED,
    parameter logic [BYTE_W-1:0] DAC_RESET   = 8'h80
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        spi_sclk,
    input  logic        spi_csn,
    input  logic        spi_sdi,
    output logic        spi_sdo,
    output logic        spi_sdo_en,
    output logic        pga1_on,
    output logic        pga2_on,
    output logic        filt_ext_sel,
    output logic        cm_high_sel,
    output logic [1:0]  stage2_gain,
    output logic        stage1_low_gain,
    output logic [7:0]  dac_code
);
    logic              csn_s, sclk_s, sdi_s;
    logic              rd_ok, wr_stb;
    logic [BYTE_W-1:0] rd_data, wr_data;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    setup_t            setup_q;
    lock_state_t       lock_q;

    cfgspi_sync #(
        .WIDTH     (3),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (3'b110)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_csn, spi_sclk, spi_sdi}),
        .q     ({csn_s, sclk_s, sdi_s})
    );

    cfgspi_frame u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (sclk_s),
        .csn_s   (csn_s),
        .sdi_s   (sdi_s),
        .rd_ok   (rd_ok),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sdo     (spi_sdo),
        .sdo_en  (spi_sdo_en)
    );

    cfgspi_regs #(
        .KEY_FIRST  (KEY_FIRST),
        .KEY_SECOND (KEY_SECOND),
        .DAC_RESET  (DAC_RESET)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_ok   (rd_ok),
        .rd_data (rd_data),
        .setup_q (setup_q),
        .dac_q   (dac_code),
        .lock_q  (lock_q)
    );

    // Break the setup register into its output fields.
    always_comb begin
        pga1_on         = setup_q.pga1_on;
        pga2_on         = setup_q.pga2_on;
        filt_ext_sel    = setup_q.filt_ext;
        cm_high_sel     = setup_q.cm_high;
        stage2_gain     = setup_q.stage2_gain;
        stage1_low_gain = setup_q.stage1_low;
    end
endmodule

// File: rtl/cfgspi_slave_chk.sv
// Property checker for cfgspi_slave, attached by bind. Watches the
// synchronized select, the write strobe, the unlock state and the outputs.
module cfgspi_slave_chk
    import cfgspi_pkg::*;
#(
    parameter logic [BYTE_W-1:0] DAC_RESET = 8'h80
) (
    input logic              clk,
    input logic              rst_n,
    input logic              csn_s,
    input logic              sdo_en,
    input lock_state_t       lock_q,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] wr_addr,
    input setup_t            setup_q,
    input logic [BYTE_W-1:0] dac_code
);
    // R8: no drive once the select has been high for a cycle
    p_idle_no_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (csn_s && $past(csn_s)) |-> !sdo_en);

    // R7: the pad is only driven while reads are open
    p_drive_only_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_en |-> lock_q == LOCK_OPEN);

    // R5: the open state is entered only from the half-keyed state
    p_open_from_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q == LOCK_OPEN && $past(lock_q) != LOCK_OPEN) |-> $past(lock_q) == LOCK_HALF);

    // R4: values right after reset release
    p_reset_values_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (setup_q == '0 && dac_code == DAC_RESET && lock_q == LOCK_SHUT));

    // R2: setup changes only on a strobe to its address
    p_setup_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && wr_addr == ADDR_SETUP) |=> $stable(setup_q));

    // R3: DAC code changes only on a strobe to its address
    p_dac_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && wr_addr == ADDR_OFFSET) |=> $stable(dac_code));
endmodule

bind cfgspi_slave cfgspi_slave_chk #(.DAC_RESET(DAC_RESET)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .csn_s    (csn_s),
    .sdo_en   (spi_sdo_en),
    .lock_q   (lock_q),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr),
    .setup_q  (setup_q),
    .dac_code (dac_code)
);

// File: tb/cfgspi_slave_test.sv
// Bench for cfgspi_slave: a vector table of frames, then directed tests
// for reset, abort, held-low select and re-locking after reset.
module cfgspi_slave_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sclk = 1'b1;
    logic       spi_csn = 1'b1;
    logic       spi_sdi = 1'b0;
    logic       spi_sdo, spi_sdo_en;
    logic       pga1_on, pga2_on, filt_ext_sel, cm_high_sel, stage1_low_gain;
    logic [1:0] stage2_gain;
    logic [7:0] dac_code;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    cfgspi_slave uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .spi_sclk        (spi_sclk),
        .spi_csn         (spi_csn),
        .spi_sdi         (spi_sdi),
        .spi_sdo         (spi_sdo),
        .spi_sdo_en      (spi_sdo_en),
        .pga1_on         (pga1_on),
        .pga2_on         (pga2_on),
        .filt_ext_sel    (filt_ext_sel),
        .cm_high_sel     (cm_high_sel),
        .stage2_gain     (stage2_gain),
        .stage1_low_gain (stage1_low_gain),
        .dac_code        (dac_code)
    );

    // {instr, data, expected setup, expected dac, expected read byte, expect drive}
    localparam int NVEC = 20;
    localparam logic [40:0] VEC [NVEC] = '{
        {8'h00, 8'h5B, 8'h5B, 8'h80, 8'h00, 1'b0},  // R2 R1 MSB-first write
        {8'h01, 8'h3C, 8'h5B, 8'h3C, 8'h00, 1'b0},  // R3
        {8'h80, 8'h00, 8'h5B, 8'h3C, 8'h00, 1'b0},  // R5 locked read
        {8'h0F, 8'hFE, 8'h5B, 8'h3C, 8'h00, 1'b0},  // R5 first key
        {8'h0F, 8'hED, 8'h5B, 8'h3C, 8'h00, 1'b0},  // R5 second key
        {8'h80, 8'h00, 8'h5B, 8'h3C, 8'h5B, 1'b1},  // R6 read setup
        {8'h81, 8'h00, 8'h5B, 8'h3C, 8'h3C, 1'b1},  // R6 read dac
        {8'h8F, 8'h00, 8'h5B, 8'h3C, 8'h00, 1'b0},  // R7 write-only address
        {8'h05, 8'hAA, 8'h5B, 8'h3C, 8'h00, 1'b0},  // R7 undefined write
        {8'h10, 8'h77, 8'h5B, 8'h3C, 8'h00, 1'b0},  // R1 reserved bits set, write
        {8'h00, 8'hFF, 8'h7F, 8'h3C, 8'h00, 1'b0},  // R2 bit 7 not stored
        {8'h80, 8'h00, 8'h7F, 8'h3C, 8'h7F, 1'b1},  // R6 R2 readback
        {8'hC1, 8'h00, 8'h7F, 8'h3C, 8'h00, 1'b0},  // R1 reserved bits set, read
        {8'h0F, 8'h11, 8'h7F, 8'h3C, 8'h00, 1'b0},  // R5 other value relocks
        {8'h81, 8'h00, 8'h7F, 8'h3C, 8'h00, 1'b0},  // R5 relocked read
        {8'h0F, 8'hFE, 8'h7F, 8'h3C, 8'h00, 1'b0},  // R5
        {8'h0F, 8'h00, 8'h7F, 8'h3C, 8'h00, 1'b0},  // R5 wrong second key
        {8'h81, 8'h00, 8'h7F, 8'h3C, 8'h00, 1'b0},  // R5 still locked
        {8'h0F, 8'hED, 8'h7F, 8'h3C, 8'h00, 1'b0},  // R5 second key alone
        {8'h81, 8'h00, 8'h7F, 8'h3C, 8'h00, 1'b0}   // R5 still locked
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] setup_pins();
        return {1'b0, pga1_on, pga2_on, filt_ext_sel, cm_high_sel, stage2_gain, stage1_low_gain};
    endfunction

    // One frame; nbits < 16 aborts early; held keeps the select untouched.
    task automatic spi_frame(input logic [7:0] instr, input logic [7:0] data,
                             input int nbits, input bit held,
                             output logic [7:0] rx, output bit drove);
        logic [15:0] fr;
        fr = {instr, data};
        rx = '0;
        drove = 1'b0;
        if (!held) begin
            spi_csn = 1'b0;
            repeat (4) @(negedge clk);
        end
        for (int i = 0; i < nbits; i++) begin
            spi_sclk = 1'b0;
            spi_sdi  = fr[15-i];
            repeat (4) @(negedge clk);
            if (i >= 8) begin
                rx = {rx[6:0], spi_sdo};
                if (spi_sdo_en) drove = 1'b1;
            end
            spi_sclk = 1'b1;
            repeat (4) @(negedge clk);
        end
        if (!held) spi_csn = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        logic [7:0] rx;
        bit drove;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R4 reset state
        check(setup_pins() == 8'h00, "R4", "setup after reset", setup_pins(), 8'h00);
        check(dac_code == 8'h80, "R4", "dac after reset", dac_code, 8'h80);
        check(spi_sdo_en == 1'b0, "R4", "no drive after reset", spi_sdo_en, 0);

        for (int v = 0; v < NVEC; v++) begin
            logic [40:0] e;
            e = VEC[v];
            spi_frame(e[40:33], e[32:25], 16, 1'b0, rx, drove);
            check(setup_pins() == e[24:17], "R2", $sformatf("vec %0d setup", v), setup_pins(), e[24:17]);
            check(dac_code == e[16:9], "R3", $sformatf("vec %0d dac", v), dac_code, e[16:9]);
            check(drove == e[0], e[0] ? "R6" : "R7", $sformatf("vec %0d drive", v), drove, e[0]);
            if (e[0])
                check(rx == e[8:1], "R6", $sformatf("vec %0d read data", v), rx, e[8:1]);
        end

        // R8 abort mid data byte, then a full frame recovers
        spi_frame(8'h00, 8'h22, 12, 1'b0, rx, drove);
        check(setup_pins() == 8'h7F, "R8", "aborted write ignored", setup_pins(), 8'h7F);
        spi_frame(8'h01, 8'h99, 16, 1'b0, rx, drove);
        check(dac_code == 8'h99, "R8", "frame after abort", dac_code, 8'h99);

        // R9 select held low for back-to-back frames
        spi_csn = 1'b0;
        repeat (6) @(negedge clk);
        spi_frame(8'h00, 8'h01, 16, 1'b1, rx, drove);
        spi_frame(8'h01, 8'h02, 16, 1'b1, rx, drove);
        check(setup_pins() == 8'h01, "R9", "held-low first frame", setup_pins(), 8'h01);
        check(dac_code == 8'h02, "R9", "held-low second frame", dac_code, 8'h02);
        spi_csn = 1'b1;
        repeat (6) @(negedge clk);

        // R4 reset mid-run after unlocking returns to defaults and locks
        spi_frame(8'h0F, 8'hFE, 16, 1'b0, rx, drove);
        spi_frame(8'h0F, 8'hED, 16, 1'b0, rx, drove);
        spi_frame(8'h81, 8'h00, 16, 1'b0, rx, drove);
        check(drove && rx == 8'h02, "R6", "open read before reset", rx, 8'h02);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(setup_pins() == 8'h00, "R4", "setup after second reset", setup_pins(), 8'h00);
        check(dac_code == 8'h80, "R4", "dac after second reset", dac_code, 8'h80);
        spi_frame(8'h81, 8'h00, 16, 1'b0, rx, drove);
        check(drove == 1'b0, "R4", "locked after second reset", drove, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule